// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Arbiter

This block decides what a processor core does each time an instruction completes. It can hand the bus to an external master, service the non-maskable interrupt, service the maskable interrupt, or fetch the next opcode as usual. The core raises an end-of-instruction strobe on the last clock of each instruction. A low WAIT input holds that instruction open, and while it is held nothing is decided. At each completed boundary the block registers exactly one grant. For the non-maskable interrupt it also supplies the fixed restart address.

The non-maskable request is captured on its falling edge into a pending latch, so a short pulse between boundaries is still serviced. The maskable request is a level. It is gated by an interrupt-enable flip-flop, which firmware sets and clears through two command inputs. Accepting either interrupt clears that flip-flop. One cycle after a grant the block drives the opcode-fetch marker. For a maskable interrupt it also drives the I/O-request marker in that same cycle. No I/O instruction ever produces that pair, so a device can take it as the interrupt acknowledge.

Top module: `intr_arbiter`

## Requirements
- R1: `grant_vld_o` is 1 in the cycle after, and only after, a clock edge at which `instr_end_i`=1 and `wait_n_i`=1 (a boundary). At that time `grant_o` carries the decision. At all other times `grant_o`=2'b00.
- R2: When `grant_o`=2'b10 (NMI) with `grant_vld_o`=1, `vec_o` equals 16'h0066. In every other cycle `vec_o` is 0.
- R3: A pending non-maskable request is granted at a boundary with `busreq_n_i`=1, whatever the state of the interrupt-enable flip-flop.
- R4: A boundary with `busreq_n_i`=0 gives `grant_o`=2'b11 (BUS). A pending non-maskable request stays pending and is granted at the next boundary that has no bus request.
- R5: While `wait_n_i`=0, a high `instr_end_i` produces no grant.
- R6: A boundary with `busreq_n_i`=1, no pending NMI and `int_n_i`=0 gives `grant_o`=2'b01 (INT) only when the enable flip-flop is set. Otherwise it gives 2'b00 (FETCH).
- R7: In the cycle after a FETCH, INT or NMI grant, `m1_o`=1. In the cycle after an INT grant, `iorq_o`=1 as well. After a BUS grant, and in all other cycles, both are 0.
- R8: A 1-to-0 transition of `nmi_n_i` sets a pending flag that holds until it is granted. A level held low yields only one NMI grant.
- R9: `ie_set_i` sets the enable flip-flop and `ie_clr_i` clears it, with clear winning over set. Accepting an INT or an NMI clears it, and that clear wins over a simultaneous `ie_set_i`.
- R10: Priority at a boundary is BUS, then NMI, then enabled INT, then FETCH.
- R11: Synchronous active-high `rst` zeroes all outputs and clears the enable flip-flop and the pending NMI flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_end_i | input | 1 | Last clock of the current instruction |
| wait_n_i | input | 1 | Wait, active low; low stalls completion |
| busreq_n_i | input | 1 | Bus request, active low |
| nmi_n_i | input | 1 | Non-maskable request, active low, edge-captured |
| int_n_i | input | 1 | Maskable request, active low, level |
| ie_set_i | input | 1 | Enable-interrupts command |
| ie_clr_i | input | 1 | Disable-interrupts command |
| grant_o | output | 2 | 00 FETCH, 01 INT, 10 NMI, 11 BUS |
| grant_vld_o | output | 1 | Grant valid pulse |
| vec_o | output | 16 | NMI restart address |
| m1_o | output | 1 | Opcode fetch cycle marker |
| iorq_o | output | 1 | I/O request; with `m1_o` it is the interrupt acknowledge |

## Verification
The assertions assume that every input is synchronous to `clk` and holds steady across each rising edge. They also assume that `instr_end_i` means one completed instruction per cycle in which it is high. The stimulus changes inputs only on the falling edge. It may raise `instr_end_i` in back-to-back cycles, which the block must treat as separate boundaries. The random phase toggles `nmi_n_i` rarely, so that pending edges overlap bus requests and enable commands, and it issues reset occasionally so that the cleared state is exercised mid-run.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  typedef enum logic [1:0] {
    GR_FETCH = 2'b00,
    GR_INT   = 2'b01,
    GR_NMI   = 2'b10,
    GR_BUS   = 2'b11
  } grant_e;

  // Fixed priority: bus master, then edge-latched NMI, then enabled INT.
  function automatic grant_e pick_grant(input logic bus_act,
                                        input logic nmi_pend,
                                        input logic int_ok);
    if (bus_act)       return GR_BUS;
    else if (nmi_pend) return GR_NMI;
    else if (int_ok)   return GR_INT;
    else               return GR_FETCH;
  endfunction
endpackage

// File: rtl/iarb_nmi_catch.sv
module iarb_nmi_catch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n_i,
  input  logic take_nmi_i,
  output logic pend_o,
  output logic fall_o
);
  logic nmi_n_q;
  logic pend_q;

  assign fall_o = nmi_n_q & ~nmi_n_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_n_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      nmi_n_q <= nmi_n_i;
      pend_q  <= fall_o | (pend_q & ~take_nmi_i);
    end
  end

  AST_NMI_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> pend_q); // R8
  AST_NMI_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    pend_q && !take_nmi_i |=> pend_q); // R8
endmodule

// File: rtl/iarb_ief.sv
module iarb_ief (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_int_i,
  input  logic take_nmi_i,
  output logic ie_o
);
  logic ie_q;
  logic accept;

  assign accept = take_int_i | take_nmi_i;
  assign ie_o   = ie_q;

  always_ff @(posedge clk) begin
    if (rst)                  ie_q <= 1'b0;
    else if (accept || clr_i) ie_q <= 1'b0;
    else if (set_i)           ie_q <= 1'b1;
  end

  AST_ACCEPT_CLEARS_IE: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ie_q); // R9
  AST_INT_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    take_int_i |-> ie_q); // R6
endmodule

// File: rtl/iarb_select.sv
module iarb_select
  import intr_arb_pkg::*;
#(
  parameter int                VEC_W   = 16,
  parameter logic [VEC_W-1:0]  NMI_VEC = 'h66
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary_i,
  input  logic             bus_act_i,
  input  logic             nmi_pend_i,
  input  logic             int_ok_i,
  output logic             take_bus_o,
  output logic             take_nmi_o,
  output logic             take_int_o,
  output grant_e           grant_o,
  output logic             vld_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam logic [VEC_W-1:0] VEC_NONE = '0;

  grant_e pick;

  assign pick       = pick_grant(bus_act_i, nmi_pend_i, int_ok_i);
  assign take_bus_o = boundary_i && (pick == GR_BUS);
  assign take_nmi_o = boundary_i && (pick == GR_NMI);
  assign take_int_o = boundary_i && (pick == GR_INT);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= GR_FETCH;
      vld_o   <= 1'b0;
      vec_o   <= VEC_NONE;
    end else begin
      grant_o <= boundary_i ? pick : GR_FETCH;
      vld_o   <= boundary_i;
      vec_o   <= take_nmi_o ? NMI_VEC : VEC_NONE;
    end
  end

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_bus_o, take_nmi_o, take_int_o})); // R10
  AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> $past(boundary_i)); // R1
  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (rst)
    vld_o && grant_o == GR_NMI |-> vec_o == NMI_VEC); // R2
  AST_BUS_FIRST: assert property (@(posedge clk) disable iff (rst)
    boundary_i && bus_act_i |=> vld_o && grant_o == GR_BUS); // R4
endmodule

// File: rtl/iarb_ack.sv
module iarb_ack
  import intr_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   vld_i,
  input  grant_e grant_i,
  output logic   m1_o,
  output logic   iorq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m1_o   <= 1'b0;
      iorq_o <= 1'b0;
    end else begin
      m1_o   <= vld_i && (grant_i != GR_BUS);
      iorq_o <= vld_i && (grant_i == GR_INT);
    end
  end

  AST_IORQ_ONLY_IN_M1: assert property (@(posedge clk) disable iff (rst)
    iorq_o |-> m1_o); // R7
  AST_ACK_AFTER_INT: assert property (@(posedge clk) disable iff (rst)
    vld_i && grant_i == GR_INT |=> iorq_o && m1_o); // R7
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_arb_pkg::*;
#(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] NMI_VEC = 'h66
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_end_i,
  input  logic             wait_n_i,
  input  logic             busreq_n_i,
  input  logic             nmi_n_i,
  input  logic             int_n_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  output logic [1:0]       grant_o,
  output logic             grant_vld_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             m1_o,
  output logic             iorq_o
);
  // Named internal events, visible to the assertions.
  logic   boundary;
  logic   nmi_pend;
  logic   nmi_fall;
  logic   ie;
  logic   int_ok;
  logic   take_bus;
  logic   take_nmi;
  logic   take_int;
  grant_e grant_q;

  assign boundary = instr_end_i & wait_n_i;
  assign int_ok   = ie & ~int_n_i;
  assign grant_o  = grant_q;

  iarb_nmi_catch u_nmi (
    .clk(clk), .rst(rst), .nmi_n_i(nmi_n_i), .take_nmi_i(take_nmi),
    .pend_o(nmi_pend), .fall_o(nmi_fall)
  );

  iarb_ief u_ief (
    .clk(clk), .rst(rst), .set_i(ie_set_i), .clr_i(ie_clr_i),
    .take_int_i(take_int), .take_nmi_i(take_nmi), .ie_o(ie)
  );

  iarb_select #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_sel (
    .clk(clk), .rst(rst), .boundary_i(boundary), .bus_act_i(~busreq_n_i),
    .nmi_pend_i(nmi_pend), .int_ok_i(int_ok),
    .take_bus_o(take_bus), .take_nmi_o(take_nmi), .take_int_o(take_int),
    .grant_o(grant_q), .vld_o(grant_vld_o), .vec_o(vec_o)
  );

  iarb_ack u_ack (
    .clk(clk), .rst(rst), .vld_i(grant_vld_o), .grant_i(grant_q),
    .m1_o(m1_o), .iorq_o(iorq_o)
  );

  AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (rst)
    !wait_n_i |=> !grant_vld_o); // R5
  AST_NMI_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    boundary && nmi_pend && busreq_n_i |=> grant_o == GR_NMI); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !grant_vld_o && !m1_o && !iorq_o); // R11
endmodule

// File: tb/intr_arbiter_bench.sv
module intr_arbiter_bench;
  logic clk = 1'b0;
  logic rst, instr_end, wait_n, busreq_n, nmi_n, int_n, ie_set, ie_clr;
  logic [1:0]  grant;
  logic        grant_vld, m1, iorq;
  logic [15:0] vec;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  // Reference state, kept by the bench.
  bit m_ie, m_pend, m_nmi_prev;
  bit e_vld, e_m1, e_iorq;
  int e_grant, e_vec;

  always #5 clk = ~clk;

  intr_arbiter u_intr_arbiter (
    .clk(clk), .rst(rst), .instr_end_i(instr_end), .wait_n_i(wait_n),
    .busreq_n_i(busreq_n), .nmi_n_i(nmi_n), .int_n_i(int_n),
    .ie_set_i(ie_set), .ie_clr_i(ie_clr), .grant_o(grant),
    .grant_vld_o(grant_vld), .vec_o(vec), .m1_o(m1), .iorq_o(iorq)
  );

  function automatic int ref_pick(bit bus_n, bit pend, bit ien, bit irq_n);
    int code;
    code = 0;
    if (ien && !irq_n) code = 1;
    if (pend)          code = 2;
    if (!bus_n)        code = 3;
    return code;
  endfunction

  function automatic string grant_tag(int g);
    case (g)
      3: return "R4";
      2: return "R3";
      1: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One clock: predict from current inputs, step, compare at the falling edge.
  task automatic cyc();
    bit bnd, fall;
    int g;
    bnd  = instr_end && wait_n;
    fall = m_nmi_prev && !nmi_n;
    e_iorq = e_vld && (e_grant == 1);
    e_m1   = e_vld && (e_grant != 3);
    if (rst) begin
      m_ie = 0; m_pend = 0; m_nmi_prev = 1;
      e_vld = 0; e_grant = 0; e_vec = 0; e_m1 = 0; e_iorq = 0;
    end else begin
      g = ref_pick(busreq_n, m_pend, m_ie, int_n);
      e_vld   = bnd;
      e_grant = bnd ? g : 0;
      e_vec   = (bnd && g == 2) ? 'h66 : 0;
      m_pend  = fall || (m_pend && !(bnd && g == 2));
      if (bnd && (g == 1 || g == 2)) m_ie = 0;
      else if (ie_clr)               m_ie = 0;
      else if (ie_set)               m_ie = 1;
      m_nmi_prev = nmi_n;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R1", "grant_vld", grant_vld, e_vld);
    chk(grant_tag(e_grant), "grant", grant, e_grant);
    chk("R2", "vec", vec, e_vec);
    chk("R7", "m1", m1, e_m1);
    chk("R7", "iorq", iorq, e_iorq);
  endtask

  task automatic idle();
    instr_end = 0; wait_n = 1; busreq_n = 1; int_n = 1;
    ie_set = 0; ie_clr = 0;
  endtask

  task automatic boundary();
    instr_end = 1; cyc(); instr_end = 0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst = 1; nmi_n = 1; idle();
    @(negedge clk);
    cyc(); cyc();
    chk("R11", "vld after reset", grant_vld, 0);
    chk("R11", "m1 after reset", m1, 0);
    rst = 0;

    // R5: held wait stalls the boundary
    instr_end = 1; wait_n = 0;
    cyc(); cyc(); cyc();
    chk("R5", "no grant in wait", grant_vld, 0);
    wait_n = 1; cyc(); instr_end = 0;
    chk("R5", "grant once wait released", grant_vld, 1);
    cyc();

    // R8: short NMI pulse between boundaries is kept
    nmi_n = 0; cyc(); nmi_n = 1; cyc(); cyc();
    boundary();
    chk("R8", "pulse serviced", grant, 2);
    chk("R2", "nmi vector", vec, 'h66);
    // NMI held low grants only once
    nmi_n = 0; cyc(); boundary(); chk("R8", "held low first", grant, 2);
    boundary(); chk("R8", "held low no repeat", grant, 0);
    nmi_n = 1; cyc();

    // R4: bus request outranks pending NMI, which stays pending
    nmi_n = 0; cyc(); nmi_n = 1;
    busreq_n = 0; boundary(); busreq_n = 1;
    chk("R4", "bus first", grant, 3);
    cyc(); chk("R7", "no m1 after bus", m1, 0);
    boundary(); chk("R4", "nmi after bus", grant, 2);

    // R10 and R9: NMI over enabled INT, and IE cleared by the accept
    ie_set = 1; cyc(); ie_set = 0;
    nmi_n = 0; cyc(); nmi_n = 1;
    int_n = 0; boundary();
    chk("R10", "nmi over int", grant, 2);
    boundary(); chk("R9", "ie cleared by nmi", grant, 0);

    // R6: INT masked, then accepted with acknowledge
    boundary(); chk("R6", "int masked", grant, 0);
    ie_set = 1; cyc(); ie_set = 0;
    boundary(); chk("R6", "int taken", grant, 1);
    cyc(); chk("R7", "ack iorq", iorq, 1); chk("R7", "ack m1", m1, 1);

    // R9: accept clear beats a simultaneous set; clear beats set
    ie_set = 1; cyc();
    boundary(); ie_set = 0;
    chk("R9", "int with set", grant, 1);
    boundary(); chk("R9", "accept beats set", grant, 0);
    ie_set = 1; ie_clr = 1; cyc(); ie_set = 0; ie_clr = 0;
    boundary(); chk("R9", "clear beats set", grant, 0);

    // R11: reset drops pending NMI and IE
    ie_set = 1; nmi_n = 0; cyc(); ie_set = 0; nmi_n = 1;
    rst = 1; cyc(); rst = 0;
    boundary(); chk("R11", "pend and ie cleared", grant, 0);
    int_n = 1;

    // Constrained random phase
    for (int i = 0; i < 3000; i++) begin
      rst       = ($urandom_range(999) < 2);
      instr_end = ($urandom_range(99) < 35);
      wait_n    = ($urandom_range(99) < 85);
      busreq_n  = ($urandom_range(99) >= 12);
      if ($urandom_range(99) < 6) nmi_n = ~nmi_n;
      int_n     = ($urandom_range(99) >= 40);
      ie_set    = ($urandom_range(99) < 12);
      ie_clr    = ($urandom_range(99) < 5);
      cyc();
    end
    rst = 0; idle(); cyc();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule